// File: doc/BRIEF.md
# Boot Strap Sampler and ROM Prefetch

This block decides how a device comes out of reset. A few clock cycles after reset is released it reads a shared boot-strap pin once and stores the result as the boot mode. If the pin reads low, the block selects ROM boot. After a short turnaround it takes ownership of the same pin and drives it as an active-low chip select for an external boot ROM.

It then copies a first-stage image of fixed size from the ROM into local memory. The ROM is read one word at a time over a synchronous request/valid interface, and the words land at local addresses starting from zero. When the last word has been accepted, the block deasserts the chip select, emits a single-cycle completion pulse and releases the core to execute from address zero.

If the pin reads high, the block never drives the pin. It waits for an external start strobe from a host or link agent and releases the core when that strobe arrives.

Top module: `boot_strap_fetch`

## Requirements
- R1: While `rst_n` is low, `strap_oe`, `rom_req`, `mem_we`, `boot_done`, `core_release` and `rom_mode` are all 0.
- R2: The strap is captured on the 4th rising clock edge after `rst_n` rises (`SAMPLE_CYC`). `rom_mode` becomes 1 when the captured value was 0 and stays 0 when it was 1. Strap changes before that edge decide the mode. Changes after that edge have no effect on `rom_mode`.
- R3: With the strap captured high, `strap_oe` stays 0 and `rom_req` stays 0 for as long as the device is out of reset.
- R4: `host_start` is honoured only while waiting in host/link mode. A one-cycle pulse there sets `core_release` on the next rising edge, and `boot_done` stays 0. A pulse before the strap is captured, or a pulse in ROM mode, leaves `core_release` at 0.
- R5: In ROM mode, `strap_oe` rises `TURN_CYC` (2) edges after the capture edge, which is the 6th edge after reset release. From that edge until the last word is accepted, `strap_out` is 0 (chip select asserted).
- R6: Beat k is requested at byte address `ROM_BASE + 4*k`. The request starts at the same edge as `strap_oe`. While `rom_rvalid` is 0, `rom_req` stays 1 and `rom_addr` holds.
- R7: Each cycle with `rom_req` and `rom_rvalid` both 1 accepts one word. It writes `rom_rdata` to `mem_addr = k` through `mem_we` in that same cycle. Exactly `WORDS` (256) writes occur, at addresses 0 to 255 in order.
- R8: On the edge after the last word is accepted, `boot_done` is 1 for exactly one cycle and `core_release` becomes 1 and stays 1. At the same edge `rom_req` drops to 0, and `strap_out` returns to 1 while `strap_oe` stays 1. `core_entry` reads 0.
- R9: Any number of wait cycles between a request and `rom_rvalid` is tolerated. `mem_we` is never 1 without `rom_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_in | input | 1 | Pin value as seen from the pad (boot mode strap) |
| host_start | input | 1 | Start strobe from host/link agent |
| rom_rvalid | input | 1 | ROM read data valid; accepts the pending beat |
| rom_rdata | input | 32 | ROM read data |
| strap_out | output | 1 | Pin drive value: active-low ROM chip select |
| strap_oe | output | 1 | Pin output enable |
| rom_mode | output | 1 | Latched mode, 1 = ROM boot |
| rom_req | output | 1 | ROM read request |
| rom_addr | output | 32 | ROM byte address of the pending beat |
| mem_we | output | 1 | Local memory write enable |
| mem_addr | output | 8 | Local memory word address |
| mem_wdata | output | 32 | Local memory write data |
| boot_done | output | 1 | One-cycle completion pulse after the copy |
| core_release | output | 1 | Core may run (sticky) |
| core_entry | output | 8 | Core start address (zero) |

## Verification
The bench moves the strap just before and just after the capture edge. A sampler that counts off by one, or that keeps following the pin, would report the wrong mode or change mode late. It runs the copy once with `rom_rvalid` returned back-to-back and once with wait states. An address counter that advances without a handshake, or a word counter that stops at 255 or runs to 257, shows up as missing, repeated or misplaced writes. It also checks the exact edge of the done pulse, the chip-select release, and the absence of pin drive in host mode. In addition it checks that start strobes arriving too early or in ROM mode are ignored, which catches a release that fires at the wrong moment.

// File: rtl/bsf_pkg.sv
package bsf_pkg;
  localparam int ROM_AW = 32;
  localparam int BEAT_BYTES = 4;

  typedef enum logic [1:0] {
    PH_WAIT  = 2'd0,
    PH_TURN  = 2'd1,
    PH_DRIVE = 2'd2,
    PH_HOST  = 2'd3
  } strap_phase_t;

  // byte address of beat idx relative to a ROM base
  function automatic logic [ROM_AW-1:0] beat_addr(input logic [ROM_AW-1:0] base,
                                                  input int unsigned idx);
    return base + (ROM_AW'(idx) * ROM_AW'(BEAT_BYTES));
  endfunction
endpackage

// File: rtl/bsf_strap_ctl.sv
module bsf_strap_ctl
  import bsf_pkg::*;
#(
  parameter int SAMPLE_CYC = 4,
  parameter int TURN_CYC   = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strap_in,
  output strap_phase_t phase,
  output logic         rom_mode,
  output logic         sample_evt,
  output logic         drive_go
);
  localparam int MAXC  = (SAMPLE_CYC > TURN_CYC) ? SAMPLE_CYC : TURN_CYC;
  localparam int DLY_W = $clog2(MAXC + 1);

  logic [DLY_W-1:0] dly;

  assign sample_evt = (phase == PH_WAIT) && (dly == DLY_W'(SAMPLE_CYC - 1));
  assign drive_go   = (phase == PH_TURN) && (dly == DLY_W'(TURN_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_WAIT;
      dly      <= '0;
      rom_mode <= 1'b0;
    end else begin
      case (phase)
        PH_WAIT: begin
          if (sample_evt) begin
            dly      <= '0;
            rom_mode <= !strap_in;
            phase    <= strap_in ? PH_HOST : PH_TURN;
          end else begin
            dly <= dly + DLY_W'(1);
          end
        end
        PH_TURN: begin
          if (drive_go) phase <= PH_DRIVE;
          else          dly   <= dly + DLY_W'(1);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bsf_copy_engine.sv
module bsf_copy_engine
  import bsf_pkg::*;
#(
  parameter int              WORDS    = 256,
  parameter int              DATA_W   = 32,
  parameter logic [ROM_AW-1:0] ROM_BASE = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     rom_rvalid,
  input  logic [DATA_W-1:0]        rom_rdata,
  output logic                     rom_req,
  output logic [ROM_AW-1:0]        rom_addr,
  output logic                     mem_we,
  output logic [$clog2(WORDS)-1:0] mem_addr,
  output logic [DATA_W-1:0]        mem_wdata,
  output logic                     beat_acc,
  output logic                     last_beat
);
  localparam int IDX_W = $clog2(WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  logic             busy;
  logic [IDX_W-1:0] idx;

  assign rom_req   = busy;
  assign beat_acc  = busy && rom_rvalid;
  assign last_beat = beat_acc && (idx == LAST_IDX);
  assign mem_we    = beat_acc;
  assign mem_addr  = idx;
  assign mem_wdata = rom_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      idx      <= '0;
      rom_addr <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      idx      <= '0;
      rom_addr <= beat_addr(ROM_BASE, 0);
    end else if (beat_acc) begin
      idx      <= idx + IDX_W'(1);
      rom_addr <= rom_addr + ROM_AW'(BEAT_BYTES);
      if (last_beat) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/bsf_release.sv
module bsf_release (
  input  logic clk,
  input  logic rst_n,
  input  logic last_beat,
  input  logic host_start,
  input  logic host_wait,
  output logic boot_done,
  output logic core_release
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_done    <= 1'b0;
      core_release <= 1'b0;
    end else begin
      boot_done <= last_beat;
      if (last_beat || (host_start && host_wait)) core_release <= 1'b1;
    end
  end
endmodule

// File: rtl/boot_strap_fetch.sv
module boot_strap_fetch
  import bsf_pkg::*;
#(
  parameter int                SAMPLE_CYC = 4,
  parameter int                TURN_CYC   = 2,
  parameter int                WORDS      = 256,
  parameter int                DATA_W     = 32,
  parameter logic [ROM_AW-1:0] ROM_BASE   = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     strap_in,
  input  logic                     host_start,
  input  logic                     rom_rvalid,
  input  logic [DATA_W-1:0]        rom_rdata,
  output logic                     strap_out,
  output logic                     strap_oe,
  output logic                     rom_mode,
  output logic                     rom_req,
  output logic [ROM_AW-1:0]        rom_addr,
  output logic                     mem_we,
  output logic [$clog2(WORDS)-1:0] mem_addr,
  output logic [DATA_W-1:0]        mem_wdata,
  output logic                     boot_done,
  output logic                     core_release,
  output logic [$clog2(WORDS)-1:0] core_entry
);
  strap_phase_t phase;
  logic sample_evt, drive_go, beat_acc, last_beat, host_wait;

  bsf_strap_ctl #(.SAMPLE_CYC(SAMPLE_CYC), .TURN_CYC(TURN_CYC)) u_strap (
    .clk(clk), .rst_n(rst_n), .strap_in(strap_in), .phase(phase),
    .rom_mode(rom_mode), .sample_evt(sample_evt), .drive_go(drive_go)
  );

  bsf_copy_engine #(.WORDS(WORDS), .DATA_W(DATA_W), .ROM_BASE(ROM_BASE)) u_copy (
    .clk(clk), .rst_n(rst_n), .start(drive_go), .rom_rvalid(rom_rvalid),
    .rom_rdata(rom_rdata), .rom_req(rom_req), .rom_addr(rom_addr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .beat_acc(beat_acc), .last_beat(last_beat)
  );

  assign host_wait = (phase == PH_HOST);

  bsf_release u_rel (
    .clk(clk), .rst_n(rst_n), .last_beat(last_beat), .host_start(host_start),
    .host_wait(host_wait), .boot_done(boot_done), .core_release(core_release)
  );

  // pin turnaround: drive once ROM mode settled; select held low while copying
  assign strap_oe   = (phase == PH_DRIVE);
  assign strap_out  = !rom_req;
  assign core_entry = '0;
endmodule

// File: rtl/bsf_checker.sv
module bsf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        rom_mode,
  input logic        strap_oe,
  input logic        strap_out,
  input logic        rom_req,
  input logic        rom_rvalid,
  input logic [31:0] rom_addr,
  input logic        mem_we,
  input logic        boot_done,
  input logic        core_release,
  input logic        sample_evt,
  input logic        beat_acc,
  input logic        last_beat
);
  a_r2_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_evt |=> $stable(rom_mode));
  a_r3_host_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    strap_oe |-> rom_mode);
  a_r4_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_release) |-> (boot_done || !rom_mode));
  a_r5_select_low: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req |-> (strap_oe && !strap_out));
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_req && !rom_rvalid) |=> (rom_req && $stable(rom_addr)));
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_acc && !last_beat) |=> (rom_addr == $past(rom_addr) + 32'd4));
  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> (boot_done && core_release && !rom_req));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> !boot_done);
  a_r8_release_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    core_release |=> core_release);
  a_r9_write_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> rom_rvalid);
endmodule

bind boot_strap_fetch bsf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rom_mode(rom_mode), .strap_oe(strap_oe),
  .strap_out(strap_out), .rom_req(rom_req), .rom_rvalid(rom_rvalid),
  .rom_addr(rom_addr), .mem_we(mem_we), .boot_done(boot_done),
  .core_release(core_release), .sample_evt(sample_evt),
  .beat_acc(beat_acc), .last_beat(last_beat)
);

// File: tb/boot_strap_fetch_test.sv
`timescale 1ns/1ps
module boot_strap_fetch_test;
  localparam int CLK_PERIOD = 10;
  localparam int NWORDS = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_in = 1'b0;
  logic host_start = 1'b0;
  logic rom_rvalid;
  logic [31:0] rom_rdata;
  logic strap_out, strap_oe, rom_mode, rom_req, mem_we, boot_done, core_release;
  logic [31:0] rom_addr, mem_wdata;
  logic [7:0] mem_addr, core_entry;

  int errors = 0;
  int checks = 0;
  int rom_lat = 0;
  int wait_c = 0;
  int wr_cnt = 0;
  bit mon_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_strap_fetch uut (
    .clk(clk), .rst_n(rst_n), .strap_in(strap_in), .host_start(host_start),
    .rom_rvalid(rom_rvalid), .rom_rdata(rom_rdata), .strap_out(strap_out),
    .strap_oe(strap_oe), .rom_mode(rom_mode), .rom_req(rom_req),
    .rom_addr(rom_addr), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .boot_done(boot_done), .core_release(core_release),
    .core_entry(core_entry)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, ~a[15:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ROM model: answers after rom_lat wait cycles, back-to-back when rom_lat is 0
  initial begin
    rom_rvalid = 1'b0;
    rom_rdata  = '0;
    forever begin
      @(posedge clk); #1;
      if (!rst_n) begin
        rom_rvalid = 1'b0; wait_c = 0;
      end else if (rom_rvalid) begin
        if (rom_req && rom_lat == 0) rom_rdata = pat(rom_addr);
        else begin rom_rvalid = 1'b0; wait_c = 0; end
      end else if (rom_req) begin
        if (wait_c >= rom_lat) begin rom_rvalid = 1'b1; rom_rdata = pat(rom_addr); end
        else wait_c++;
      end
    end
  end

  // write monitor: order, address and data of every beat (R6, R7, R9)
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && mem_we) begin
        chk(rom_rvalid, "R9", "write without valid", 32'(rom_rvalid), 32'd1);
        chk(mem_addr == 8'(wr_cnt), "R7", "write address", 32'(mem_addr), 32'(wr_cnt));
        chk(mem_wdata == pat(32'(wr_cnt) * 4), "R7", "write data", mem_wdata, pat(32'(wr_cnt) * 4));
        chk(rom_addr == 32'(wr_cnt) * 4, "R6", "beat address", rom_addr, 32'(wr_cnt) * 4);
        chk(strap_oe && !strap_out, "R5", "select during copy", {30'd0, strap_oe, strap_out}, 32'd2);
        wr_cnt++;
      end
    end
  end

  task automatic do_reset(input logic strap);
    mon_on = 1'b0;
    @(negedge clk);
    rst_n = 1'b0; strap_in = strap; host_start = 1'b0;
    repeat (3) @(negedge clk);
    chk(!strap_oe && !rom_req && !mem_we && !boot_done && !core_release && !rom_mode,
        "R1", "outputs in reset",
        {26'd0, strap_oe, rom_req, mem_we, boot_done, core_release, rom_mode}, 32'd0);
    wr_cnt = 0;
    mon_on = 1'b1;
    rst_n = 1'b1;
  endtask

  task automatic t_rom_boot(input int lat, input bit early_high);
    bit prev_last = 1'b0;
    bit rel_early = 1'b0;
    int guard = 0;
    rom_lat = lat;
    do_reset(early_high);
    @(negedge clk); // edge 1
    chk(!strap_oe, "R5", "oe after edge1", 32'(strap_oe), 32'd0);
    @(negedge clk); // edge 2
    if (early_high) strap_in = 1'b0;
    @(negedge clk); // edge 3
    chk(!rom_mode, "R2", "mode before capture", 32'(rom_mode), 32'd0);
    @(negedge clk); // edge 4
    chk(rom_mode, "R2", "low strap gives ROM mode", 32'(rom_mode), 32'd1);
    strap_in = 1'b1;
    @(negedge clk); // edge 5
    chk(!strap_oe && !rom_req, "R5", "no drive during turnaround", {30'd0, strap_oe, rom_req}, 32'd0);
    @(negedge clk); // edge 6
    chk(strap_oe && !strap_out, "R5", "drive and select at edge6", {30'd0, strap_oe, strap_out}, 32'd2);
    chk(rom_req && rom_addr == 32'd0, "R6", "first request at base", rom_addr, 32'd0);
    host_start = 1'b1;
    while (!boot_done && guard < 5000) begin
      prev_last = mem_we && (mem_addr == 8'hFF);
      if (core_release) rel_early = 1'b1;
      @(negedge clk);
      host_start = 1'b0;
      guard++;
    end
    chk(!rel_early, "R4", "host strobe ignored in ROM mode", 32'(rel_early), 32'd0);
    chk(boot_done && prev_last, "R8", "done on edge after last beat", {30'd0, boot_done, prev_last}, 32'd3);
    chk(core_release && strap_oe && strap_out && !rom_req, "R8", "release and deselect",
        {28'd0, core_release, strap_oe, strap_out, rom_req}, 32'hE);
    chk(core_entry == 8'd0, "R8", "entry address", 32'(core_entry), 32'd0);
    @(negedge clk);
    chk(!boot_done && core_release, "R8", "done is one cycle", {30'd0, boot_done, core_release}, 32'd1);
    chk(wr_cnt == NWORDS, "R7", "word count", 32'(wr_cnt), 32'(NWORDS));
    chk(rom_mode, "R2", "late strap change ignored", 32'(rom_mode), 32'd1);
    repeat (4) @(negedge clk);
    chk(!mem_we && wr_cnt == NWORDS && core_release, "R8", "quiet after done", 32'(wr_cnt), 32'(NWORDS));
  endtask

  task automatic t_host_boot();
    bit drove = 1'b0;
    do_reset(1'b1);
    @(negedge clk); // edge 1
    host_start = 1'b1;
    @(negedge clk); // edge 2
    host_start = 1'b0;
    @(negedge clk); // edge 3
    chk(!core_release, "R4", "strobe before capture ignored", 32'(core_release), 32'd0);
    @(negedge clk); // edge 4
    chk(!rom_mode, "R2", "high strap gives host mode", 32'(rom_mode), 32'd0);
    strap_in = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (strap_oe || rom_req || mem_we) drove = 1'b1;
    end
    chk(!drove, "R3", "pin never driven in host mode", 32'(drove), 32'd0);
    chk(!rom_mode && !core_release, "R3", "still waiting", {30'd0, rom_mode, core_release}, 32'd0);
    host_start = 1'b1;
    @(negedge clk);
    host_start = 1'b0;
    chk(core_release && !boot_done, "R4", "host strobe releases", {30'd0, core_release, boot_done}, 32'd2);
    chk(core_entry == 8'd0, "R4", "entry address", 32'(core_entry), 32'd0);
    repeat (3) @(negedge clk);
    chk(core_release && !strap_oe, "R3", "released without drive", {30'd0, core_release, strap_oe}, 32'd2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_rom_boot(0, 1'b0);
    t_rom_boot(3, 1'b1);
    t_host_boot();
    t_rom_boot(1, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule